// File: doc/BRIEF.md
# Multi-Lane Readout Word Serializer

This block streams 24-bit readout words onto a group of serial output lanes. It is clocked by the readout clock, which is independent of the beam-crossing clock. Words come from the hit-sorting core through a valid/ready handshake. A hit offered at a word boundary is packed into a data word from its strip, logic-set and crossing-stamp fields. When no hit is offered at a boundary, the block sends a sync/status word instead, so the lanes never go idle.

A two-bit select sets the number of active lanes to 1, 2, 4 or 6. The word is cut into equal contiguous slices, one per active lane, and every lane shifts its slice out most significant bit first. A word therefore takes 24, 12, 6 or 4 clocks. Nothing is buffered: each word is sent in the order it is accepted. The lane setting is sampled only when a word is loaded.

Top module: `rdo_word_serializer`

## Requirements
- R1: While reset is low, every lane output is 0.
- R2: A hit accepted at a boundary is sent as a data word. Bit 23 is 1, bits 22..17 are 0, bits 16..13 hold the strip, bits 12..8 hold the logic set, and bits 7..0 hold the crossing stamp.
- R3: When no hit is valid at a boundary, a sync/status word is sent. Bit 23 is 0, bits 22..10 hold 13'h1A5F, and bits 9..0 hold the status input sampled at that boundary.
- R4: A lane select of 0, 1, 2 or 3 gives 1, 2, 4 or 6 lanes. Lane k carries bits 23-k*L down to 24-(k+1)*L, where L = 24 / lanes, and sends them MSB first, one bit per clock.
- R5: A word lasts exactly L clocks. hit_ready is high only in the last clock of a word, which is the cycle before a boundary edge.
- R6: Lanes at or above the active lane count stay at 0.
- R7: A change of lane_sel during a word has no effect until the next boundary.
- R8: hit_valid and the hit fields are ignored while hit_ready is low. The word presented at the boundary is the one that is sent, starting in the very next cycle.
- R9: The first word begins on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | A hit is offered |
| hit_ready | output | 1 | The hit is taken on this edge (word boundary) |
| hit_strip | input | 4 | Strip within the logic set |
| hit_set | input | 5 | Logic-set number |
| hit_bco | input | 8 | Crossing stamp of the hit |
| status_bits | input | 10 | Status carried in sync words |
| lane_sel | input | 2 | Lane count select |
| lane_o | output | 6 | Serial lane outputs, lane 0 is the most significant slice |

## Verification
The hardest case to reach from the ports is a lane-select change that lands in the middle of a word, together with a hit that is offered while the block is not ready. Only in that case can a new setting wrongly re-slice a word that is already in flight, or a stray hit slip in early. On every non-boundary cycle the bench drives lane_sel, hit_valid and the hit fields with pseudo-random values. At each boundary it sets the intended values, then checks every lane bit against a slice it computes itself. It sweeps all four lane counts, both slowly and with a new count on every word, under all-hit, all-idle and mixed traffic.

// File: rtl/rdo_ser_pkg.sv
package rdo_ser_pkg;
  localparam int WORD_W    = 24;
  localparam int MAX_LANES = 6;
  localparam int STRIP_W   = 4;
  localparam int SET_W     = 5;
  localparam int BCO_W     = 8;
  localparam int STAT_W    = 10;
  localparam int SYNC_W    = 13;
  localparam int ADC_W     = 3;
  localparam int SPARE_W   = WORD_W - 1 - ADC_W - STRIP_W - SET_W - BCO_W;
  localparam int CNT_W     = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {LANES_1 = 2'd0, LANES_2 = 2'd1, LANES_4 = 2'd2, LANES_6 = 2'd3} lane_sel_e;

  function automatic int unsigned lane_count(lane_sel_e s);
    case (s)
      LANES_1: return 1;
      LANES_2: return 2;
      LANES_4: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] slice_len(lane_sel_e s);
    return CNT_W'(WORD_W / lane_count(s));
  endfunction

  function automatic logic [MAX_LANES-1:0] lane_mask(lane_sel_e s);
    return MAX_LANES'((1 << lane_count(s)) - 1);
  endfunction

  function automatic word_t pack_data(logic [STRIP_W-1:0] strip, logic [SET_W-1:0] set,
                                      logic [BCO_W-1:0] bco);
    return {1'b1, {ADC_W{1'b0}}, {SPARE_W{1'b0}}, strip, set, bco};
  endfunction

  function automatic word_t pack_sync(logic [SYNC_W-1:0] pattern, logic [STAT_W-1:0] status);
    return {1'b0, pattern, status};
  endfunction

  // Slice for one lane, left-aligned so the lane shifts it out MSB first.
  function automatic word_t lane_slice(word_t w, int unsigned lane, lane_sel_e s);
    int unsigned len;
    word_t ones;
    word_t mask;
    len  = WORD_W / lane_count(s);
    ones = '1;
    mask = ~(ones >> len);
    if (lane >= lane_count(s)) return '0;
    return (w << (lane * len)) & mask;
  endfunction
endpackage

// File: rtl/rdo_word_fmt.sv
module rdo_word_fmt
  import rdo_ser_pkg::*;
#(
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 13'h1A5F
) (
  input  logic               hit_valid,
  input  logic [STRIP_W-1:0] hit_strip,
  input  logic [SET_W-1:0]   hit_set,
  input  logic [BCO_W-1:0]   hit_bco,
  input  logic [STAT_W-1:0]  status_bits,
  output word_t              word
);
  always_comb begin
    if (hit_valid) word = pack_data(hit_strip, hit_set, hit_bco);
    else           word = pack_sync(SYNC_PATTERN, status_bits);
  end
endmodule

// File: rtl/rdo_bit_timer.sv
module rdo_bit_timer
  import rdo_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lane_sel_e        sel_in,
  output logic             word_load,
  output lane_sel_e        cur_sel,
  output logic [CNT_W-1:0] bits_left
);
  assign word_load = (bits_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_left <= '0;
      cur_sel   <= LANES_1;
    end else if (word_load) begin
      bits_left <= slice_len(sel_in) - 1'b1;
      cur_sel   <= sel_in;
    end else begin
      bits_left <= bits_left - 1'b1;
    end
  end
endmodule

// File: rtl/rdo_lane_shifter.sv
module rdo_lane_shifter
  import rdo_ser_pkg::*;
#(
  parameter int unsigned LANE_IDX = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      word_load,
  input  word_t     word,
  input  lane_sel_e sel_in,
  output logic      lane_bit
);
  word_t sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh_q <= '0;
    else if (word_load) sh_q <= lane_slice(word, LANE_IDX, sel_in);
    else                sh_q <= sh_q << 1;
  end

  assign lane_bit = sh_q[WORD_W-1];
endmodule

// File: rtl/rdo_word_serializer.sv
module rdo_word_serializer
  import rdo_ser_pkg::*;
#(
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 13'h1A5F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_valid,
  output logic                 hit_ready,
  input  logic [STRIP_W-1:0]   hit_strip,
  input  logic [SET_W-1:0]     hit_set,
  input  logic [BCO_W-1:0]     hit_bco,
  input  logic [STAT_W-1:0]    status_bits,
  input  logic [1:0]           lane_sel,
  output logic [MAX_LANES-1:0] lane_o
);
  word_t            next_word;
  logic             word_load;
  lane_sel_e        cur_sel;
  lane_sel_e        sel_in;
  logic [CNT_W-1:0] bits_left;

  assign sel_in    = lane_sel_e'(lane_sel);
  assign hit_ready = word_load;

  rdo_word_fmt #(.SYNC_PATTERN(SYNC_PATTERN)) u_fmt (
    .hit_valid  (hit_valid),
    .hit_strip  (hit_strip),
    .hit_set    (hit_set),
    .hit_bco    (hit_bco),
    .status_bits(status_bits),
    .word       (next_word)
  );

  rdo_bit_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_in   (sel_in),
    .word_load(word_load),
    .cur_sel  (cur_sel),
    .bits_left(bits_left)
  );

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    rdo_lane_shifter #(.LANE_IDX(g)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_load(word_load),
      .word     (next_word),
      .sel_in   (sel_in),
      .lane_bit (lane_o[g])
    );
  end
endmodule

// File: rtl/rdo_ser_chk.sv
module rdo_ser_chk
  import rdo_ser_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hit_valid,
  input logic [1:0]           lane_sel,
  input logic [MAX_LANES-1:0] lane_o,
  input logic                 word_load,
  input lane_sel_e            cur_sel,
  input logic [CNT_W-1:0]     bits_left
);
  logic [MAX_LANES-1:0] active_mask;
  assign active_mask = lane_mask(cur_sel);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> lane_o == '0); // R1
  AST_DATA_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    word_load && hit_valid |=> lane_o[0]); // R2
  AST_SYNC_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    word_load && !hit_valid |=> !lane_o[0]); // R3
  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    word_load && (slice_len(lane_sel_e'(lane_sel)) > 1) |=> !word_load); // R5
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left < slice_len(cur_sel)); // R5
  AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_o & ~active_mask) == '0); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_load |=> $stable(cur_sel)); // R7
endmodule

bind rdo_word_serializer rdo_ser_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hit_valid(hit_valid),
  .lane_sel (lane_sel),
  .lane_o   (lane_o),
  .word_load(word_load),
  .cur_sel  (cur_sel),
  .bits_left(bits_left)
);

// File: tb/rdo_word_serializer_tb_top.sv
module rdo_word_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hit_valid;
  logic       hit_ready;
  logic [3:0] hit_strip;
  logic [4:0] hit_set;
  logic [7:0] hit_bco;
  logic [9:0] status_bits;
  logic [1:0] lane_sel;
  logic [5:0] lane_o;

  always #5 clk = ~clk;

  rdo_word_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_strip(hit_strip), .hit_set(hit_set), .hit_bco(hit_bco),
    .status_bits(status_bits), .lane_sel(lane_sel), .lane_o(lane_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] rng = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_rng();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
  endtask

  function automatic int nlanes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 6;
  endfunction

  // R2: mark, six zero bits, strip, set, stamp
  function automatic logic [23:0] mk_data(logic [3:0] st, logic [4:0] se, logic [7:0] b);
    return (24'h1 << 23) | (24'(st) << 13) | (24'(se) << 8) | 24'(b);
  endfunction

  // R3: mark 0, sync pattern, status
  function automatic logic [23:0] mk_sync(logic [9:0] s);
    return (24'h1A5F << 10) | 24'(s);
  endfunction

  logic [23:0] m_word;
  logic [1:0]  m_sel;
  int          m_pos;
  bit          started;
  bit          first_word;
  bit          early_valid;
  bit          m_early;
  int          wcount;

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL R5 watchdog: actual not finished expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hit_valid = 1'b0; hit_strip = '0; hit_set = '0; hit_bco = '0;
    status_bits = '0; lane_sel = 2'd0;
    started = 0; wcount = 0; early_valid = 0; m_early = 0; first_word = 0;
    m_word = '0; m_sel = '0; m_pos = 0;
    repeat (4) begin
      @(negedge clk);
      chk(lane_o == 6'd0, "R1", 32'(lane_o), 0);
    end
    rst_n = 1'b1;
    while (wcount < 260 || (started && m_pos != 24 / nlanes(m_sel) - 1)) begin
      bit boundary;
      if (started) begin
        for (int i = 0; i < 6; i++) begin
          int n;
          int len;
          logic expb;
          string lbl;
          n = nlanes(m_sel);
          len = 24 / n;
          expb = (i < n) ? m_word[23 - i * len - m_pos] : 1'b0;
          if (i >= n) lbl = "R6";
          else if (first_word) lbl = "R9";
          else if (i == 0 && m_pos == 0) lbl = m_word[23] ? (m_early ? "R2 R8" : "R2") : "R3";
          else if (lane_sel != m_sel) lbl = "R7";
          else lbl = "R4";
          chk(lane_o[i] == expb, lbl, 32'(lane_o[i]), 32'(expb));
        end
      end
      boundary = !started || (m_pos == 24 / nlanes(m_sel) - 1);
      chk(hit_ready == boundary, "R5", 32'(hit_ready), 32'(boundary));
      if (boundary && wcount < 260) begin
        int mode;
        mode = (wcount / 5) % 3;
        step_rng();
        lane_sel = (wcount < 160) ? 2'((wcount / 10) % 4) : 2'(wcount % 4);
        hit_valid = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : rng[3];
        step_rng(); hit_strip = rng[3:0]; hit_set = rng[8:4]; hit_bco = rng[15:8];
        step_rng(); status_bits = rng[9:0];
        m_word = hit_valid ? mk_data(hit_strip, hit_set, hit_bco) : mk_sync(status_bits);
        m_sel = lane_sel;
        m_pos = 0;
        m_early = early_valid;
        early_valid = 0;
        first_word = !started;
        started = 1;
        wcount++;
      end else if (!boundary) begin
        m_pos++;
        // R7 R8: junk on every input while not ready
        step_rng();
        hit_valid = rng[0];
        lane_sel = rng[2:1];
        hit_strip = rng[6:3]; hit_set = rng[11:7];
        step_rng();
        hit_bco = rng[7:0]; status_bits = rng[15:6];
        if (hit_valid) early_valid = 1;
      end else begin
        started = 0;
      end
      @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule